// File: doc/BRIEF.md
# Auto-reload capture timer

This block is a counter with a programmable reload. Run as one 16-bit counter, it loads the reload value back into the count each time the count passes its all-ones state, and it raises an overflow flag. Run in split mode, it becomes two separate 8-bit counters. The low byte and the high byte each reload from their own half of the reload register. Each byte has its own overflow flag, and the high byte has its own run enable. A two-bit select picks the rate at which the counter advances. The choices are every system clock, every twelfth system clock, every eighth rising edge of a slow clock, or every rising edge of a comparator output. The slow clock and the comparator output are both brought in through synchronisers.

In capture mode the counter advances on every system clock, whatever the select says. The count is sampled on each rising edge of a slow reference input. The sample goes into the reload register, which serves as the capture register in this mode, and a sticky flag is set. Software reads two successive captures and subtracts them. The difference is the period of the reference, measured in system clock cycles.

Software reaches the block through a small write port. Address 0 writes the count, address 1 writes the reload register, and address 2 clears flags. The count, the reload/capture register and the flags are always visible on registered outputs.

Top module: `reload_cap_timer`

## Requirements
- R1: When the synchronous reset is asserted, the count, the reload register, ovf_lo, ovf_hi and cap_flag all go to zero on the next clock edge.
- R2: A write with wr_addr 0 loads wr_data into the count. A write with wr_addr 1 loads the reload register. Writing the count takes priority over counting in the same cycle, so the written value appears on the next cycle even while the counter runs.
- R3: In 16-bit mode (split_en=0, capture_en=0) the counter advances on each tick while run_lo=1. The tick that finds the count at 0xFFFF loads the reload value instead, and ovf_lo is set on that same edge.
- R4: Outside capture mode, a counter half whose run enable is 0 holds its value. This is run_lo for the whole count, or for the low byte in split mode, and run_hi for the high byte in split mode.
- R5: In split mode the low byte counts on each tick while run_lo=1. From 0xFF it reloads reload[7:0] and sets ovf_lo. It never carries into the high byte.
- R6: In split mode the high byte counts on the same tick while run_hi=1. From 0xFF it reloads reload[15:8] and sets ovf_hi.
- R7: clk_sel selects the tick source. Code 0 ticks on every cycle. Code 1 ticks on one cycle in twelve. Code 2 ticks on one in every eight rising edges of slow_clk. Code 3 ticks on each rising edge of cmp_in. slow_clk and cmp_in each pass through two synchroniser flops before edge detection.
- R8: With capture_en=1 and run_lo=1, the count advances by one on every system clock, whatever clk_sel and split_en say. It wraps from 0xFFFF to 0 and sets ovf_lo. On each rising edge of cap_in after two synchroniser flops, the current count is copied into the reload register and cap_flag is set. The difference between successive captures therefore equals the period of cap_in in system clock cycles.
- R9: ovf_lo, ovf_hi and cap_flag stay set until software clears them. A write with wr_addr 2 clears ovf_lo when wr_data[0]=1, ovf_hi when wr_data[1]=1 and cap_flag when wr_data[2]=1. A flag that is set and cleared in the same cycle ends up set.
- R10: With capture_en=0, edges on cap_in change neither the reload register nor cap_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 count, 1 reload, 2 flag clear |
| wr_data | input | 16 | Write data |
| clk_sel | input | 2 | Tick source select |
| slow_clk | input | 1 | Slow asynchronous clock, divided by 8 |
| cmp_in | input | 1 | Asynchronous comparator output |
| cap_in | input | 1 | Asynchronous capture reference |
| split_en | input | 1 | Two 8-bit counters instead of one 16-bit counter |
| capture_en | input | 1 | Capture mode |
| run_lo | input | 1 | Run enable for the 16-bit count or the low byte |
| run_hi | input | 1 | Run enable for the high byte in split mode |
| count_o | output | 16 | Current count |
| reload_o | output | 16 | Reload or capture register |
| ovf_lo | output | 1 | Sticky overflow of the 16-bit count or the low byte |
| ovf_hi | output | 1 | Sticky overflow of the high byte |
| cap_flag | output | 1 | Sticky capture flag |

## Verification
The bench runs the counter through the all-ones state, both as a single 16-bit count and with the two bytes wrapping on their own. A design that carried from the low byte into the high byte in split mode, or that put the reload value in one cycle late, would end on a different count than the hand-computed one. The prescaled sources are checked over a whole number of prescaler periods. A divider that was off by one, or that counted both edges of the slow clock or the comparator output, would then yield the wrong tick total. In capture mode the select is left at the twelve-cycle setting and a reference with a 40-cycle period is applied. A design that kept obeying the select during capture, or that lost the count between two samples, would report a period other than 40. Captures that leaked through while capture mode was off would show up as a changed reload register or a raised flag.

// File: rtl/rct_pkg.sv
package rct_pkg;
  typedef enum logic [1:0] {
    SRC_SYS  = 2'd0,
    SRC_DIV  = 2'd1,
    SRC_SLOW = 2'd2,
    SRC_CMP  = 2'd3
  } tick_src_e;

  typedef enum logic [1:0] {
    ADR_COUNT  = 2'd0,
    ADR_RELOAD = 2'd1,
    ADR_FLAGS  = 2'd2,
    ADR_NONE   = 2'd3
  } reg_adr_e;

  localparam int FLG_LO  = 0;
  localparam int FLG_HI  = 1;
  localparam int FLG_CAP = 2;
endpackage

// File: rtl/rct_sync_edge.sv
module rct_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] sq;
  logic              last_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sq[0] <= 1'b0;
          else     sq[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sq[g] <= 1'b0;
          else     sq[g] <= sq[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= sq[STAGES-1];
  end

  assign rise = sq[STAGES-1] & ~last_q;
endmodule

// File: rtl/rct_tick_gen.sv
module rct_tick_gen
  import rct_pkg::*;
#(
  parameter int SYS_DIV  = 12,
  parameter int SLOW_DIV = 8,
  parameter int SYNC_N   = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  tick_src_e sel,
  input  logic      slow_clk,
  input  logic      cmp_in,
  output logic      tick
);
  localparam int DW = (SYS_DIV  > 1) ? $clog2(SYS_DIV)  : 1;
  localparam int SW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST  = DW'(SYS_DIV - 1);
  localparam logic [SW-1:0] SLOW_LAST = SW'(SLOW_DIV - 1);

  logic [DW-1:0] div_q;
  logic [SW-1:0] slow_q;
  logic          slow_rise;
  logic          cmp_rise;

  rct_sync_edge #(.STAGES(SYNC_N)) u_slow_sync (
    .clk(clk), .rst(rst), .async_in(slow_clk), .rise(slow_rise)
  );

  rct_sync_edge #(.STAGES(SYNC_N)) u_cmp_sync (
    .clk(clk), .rst(rst), .async_in(cmp_in), .rise(cmp_rise)
  );

  always_ff @(posedge clk) begin
    if (rst)                   div_q <= '0;
    else if (div_q == DIV_LAST) div_q <= '0;
    else                       div_q <= div_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) slow_q <= '0;
    else if (slow_rise) begin
      if (slow_q == SLOW_LAST) slow_q <= '0;
      else                     slow_q <= slow_q + 1'b1;
    end
  end

  always_comb begin
    unique case (sel)
      SRC_SYS:  tick = 1'b1;
      SRC_DIV:  tick = (div_q == DIV_LAST);
      SRC_SLOW: tick = slow_rise && (slow_q == SLOW_LAST);
      SRC_CMP:  tick = cmp_rise;
      default:  tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/rct_core.sv
module rct_core
  import rct_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             cap_edge,
  input  logic             wr_en,
  input  reg_adr_e         wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             split_en,
  input  logic             capture_en,
  input  logic             run_lo,
  input  logic             run_hi,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] rld_q,
  output logic             ovf_lo_q,
  output logic             ovf_hi_q,
  output logic             cap_q
);
  localparam int HW = CNT_W / 2;
  localparam logic [HW-1:0] HALF_ONES = '1;
  localparam logic [CNT_W-1:0] FULL_ONES = '1;

  logic wr_cnt, wr_rld, wr_flg;
  logic [HW-1:0] lo_cur, hi_cur;

  assign wr_cnt = wr_en && (wr_addr == ADR_COUNT);
  assign wr_rld = wr_en && (wr_addr == ADR_RELOAD);
  assign wr_flg = wr_en && (wr_addr == ADR_FLAGS);
  assign lo_cur = cnt_q[HW-1:0];
  assign hi_cur = cnt_q[CNT_W-1:HW];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      rld_q    <= '0;
      ovf_lo_q <= 1'b0;
      ovf_hi_q <= 1'b0;
      cap_q    <= 1'b0;
    end else begin
      // clears first so that a set later in this block wins
      if (wr_flg) begin
        if (wr_data[FLG_LO])  ovf_lo_q <= 1'b0;
        if (wr_data[FLG_HI])  ovf_hi_q <= 1'b0;
        if (wr_data[FLG_CAP]) cap_q    <= 1'b0;
      end

      if (wr_cnt) begin
        cnt_q <= wr_data;
      end else if (capture_en) begin
        if (run_lo) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == FULL_ONES) ovf_lo_q <= 1'b1;
        end
      end else if (split_en) begin
        if (run_lo && tick) begin
          if (lo_cur == HALF_ONES) begin
            cnt_q[HW-1:0] <= rld_q[HW-1:0];
            ovf_lo_q      <= 1'b1;
          end else begin
            cnt_q[HW-1:0] <= lo_cur + 1'b1;
          end
        end
        if (run_hi && tick) begin
          if (hi_cur == HALF_ONES) begin
            cnt_q[CNT_W-1:HW] <= rld_q[CNT_W-1:HW];
            ovf_hi_q          <= 1'b1;
          end else begin
            cnt_q[CNT_W-1:HW] <= hi_cur + 1'b1;
          end
        end
      end else if (run_lo && tick) begin
        if (cnt_q == FULL_ONES) begin
          cnt_q    <= rld_q;
          ovf_lo_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end

      if (capture_en && cap_edge) begin
        rld_q <= cnt_q;
        cap_q <= 1'b1;
      end else if (wr_rld) begin
        rld_q <= wr_data;
      end
    end
  end
endmodule

// File: rtl/reload_cap_timer.sv
module reload_cap_timer
  import rct_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int SYS_DIV  = 12,
  parameter int SLOW_DIV = 8,
  parameter int SYNC_N   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       clk_sel,
  input  logic             slow_clk,
  input  logic             cmp_in,
  input  logic             cap_in,
  input  logic             split_en,
  input  logic             capture_en,
  input  logic             run_lo,
  input  logic             run_hi,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] reload_o,
  output logic             ovf_lo,
  output logic             ovf_hi,
  output logic             cap_flag
);
  logic tick;
  logic cap_edge;

  rct_tick_gen #(
    .SYS_DIV(SYS_DIV), .SLOW_DIV(SLOW_DIV), .SYNC_N(SYNC_N)
  ) u_tick (
    .clk(clk), .rst(rst), .sel(tick_src_e'(clk_sel)),
    .slow_clk(slow_clk), .cmp_in(cmp_in), .tick(tick)
  );

  rct_sync_edge #(.STAGES(SYNC_N)) u_cap_sync (
    .clk(clk), .rst(rst), .async_in(cap_in), .rise(cap_edge)
  );

  rct_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .tick(tick), .cap_edge(cap_edge),
    .wr_en(wr_en), .wr_addr(reg_adr_e'(wr_addr)), .wr_data(wr_data),
    .split_en(split_en), .capture_en(capture_en),
    .run_lo(run_lo), .run_hi(run_hi),
    .cnt_q(count_o), .rld_q(reload_o),
    .ovf_lo_q(ovf_lo), .ovf_hi_q(ovf_hi), .cap_q(cap_flag)
  );
endmodule

// File: rtl/reload_cap_timer_chk.sv
module reload_cap_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [CNT_W-1:0] wr_data,
  input logic [1:0]       clk_sel,
  input logic             split_en,
  input logic             capture_en,
  input logic             run_lo,
  input logic             run_hi,
  input logic [CNT_W-1:0] count_o,
  input logic [CNT_W-1:0] reload_o,
  input logic             ovf_lo,
  input logic             ovf_hi,
  input logic             cap_flag
);
  localparam int HW = CNT_W / 2;
  localparam logic [CNT_W-1:0] ONES = '1;

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (count_o == '0 && reload_o == '0 && !ovf_lo && !ovf_hi && !cap_flag));

  a_r3_reload_on_wrap: assert property (@(posedge clk) disable iff (rst)
    (!capture_en && !split_en && run_lo && clk_sel == 2'd0 && !wr_en && count_o == ONES)
    |=> (count_o == $past(reload_o) && ovf_lo));

  a_r4_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!capture_en && !run_lo && !run_hi && !wr_en) |=> $stable(count_o));

  a_r5_no_carry_up: assert property (@(posedge clk) disable iff (rst)
    (split_en && !capture_en && !run_hi && !wr_en)
    |=> (count_o[CNT_W-1:HW] == $past(count_o[CNT_W-1:HW])));

  a_r8_capture_value: assert property (@(posedge clk) disable iff (rst)
    $rose(cap_flag) |-> (reload_o == $past(count_o)));

  a_r9_cap_sticky: assert property (@(posedge clk) disable iff (rst)
    (cap_flag && !(wr_en && wr_addr == 2'd2 && wr_data[2])) |=> cap_flag);

  a_r9_lo_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf_lo && !(wr_en && wr_addr == 2'd2 && wr_data[0])) |=> ovf_lo);
endmodule

bind reload_cap_timer reload_cap_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .clk_sel(clk_sel), .split_en(split_en), .capture_en(capture_en),
  .run_lo(run_lo), .run_hi(run_hi), .count_o(count_o), .reload_o(reload_o),
  .ovf_lo(ovf_lo), .ovf_hi(ovf_hi), .cap_flag(cap_flag)
);

// File: tb/reload_cap_timer_tb.sv
`timescale 1ns/1ps
module reload_cap_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = '0;
  logic [1:0]  clk_sel = 2'd0;
  logic        slow_clk = 1'b0;
  logic        cmp_in = 1'b0;
  logic        cap_in = 1'b0;
  logic        split_en = 1'b0;
  logic        capture_en = 1'b0;
  logic        run_lo = 1'b0;
  logic        run_hi = 1'b0;
  logic [15:0] count_o, reload_o;
  logic        ovf_lo, ovf_hi, cap_flag;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit cap_on = 0;
  int cap_ph = 0;

  always #10 clk = ~clk;

  reload_cap_timer dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .clk_sel(clk_sel), .slow_clk(slow_clk), .cmp_in(cmp_in), .cap_in(cap_in),
    .split_en(split_en), .capture_en(capture_en), .run_lo(run_lo), .run_hi(run_hi),
    .count_o(count_o), .reload_o(reload_o), .ovf_lo(ovf_lo), .ovf_hi(ovf_hi),
    .cap_flag(cap_flag)
  );

  typedef struct packed {
    logic        split;
    logic        rl;
    logic        rh;
    logic [15:0] cnt;
    logic [15:0] rld;
    logic [7:0]  n;
    logic [15:0] exp;
    logic        elo;
    logic        ehi;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 1'b0, 16'h0010, 16'h1234, 8'd5,  16'h0015, 1'b0, 1'b0}, // R3 plain count
    '{1'b0, 1'b1, 1'b0, 16'hFFFE, 16'h1234, 8'd1,  16'hFFFF, 1'b0, 1'b0}, // R3 reach all-ones
    '{1'b0, 1'b1, 1'b0, 16'hFFFE, 16'h1234, 8'd2,  16'h1234, 1'b1, 1'b0}, // R3 reload
    '{1'b0, 1'b1, 1'b0, 16'hFFFF, 16'hFFF0, 8'd20, 16'hFFF3, 1'b1, 1'b0}, // R3 repeated reload
    '{1'b1, 1'b1, 1'b1, 16'h10FE, 16'h80F0, 8'd3,  16'h13F1, 1'b1, 1'b0}, // R5 low wrap
    '{1'b1, 1'b1, 1'b1, 16'hFFFD, 16'h4020, 8'd4,  16'h4321, 1'b1, 1'b1}, // R6 both wrap
    '{1'b1, 1'b1, 1'b0, 16'h55FF, 16'h00AA, 8'd2,  16'h55AB, 1'b1, 1'b0}, // R5 no carry
    '{1'b0, 1'b0, 1'b0, 16'h0100, 16'h0000, 8'd10, 16'h0100, 1'b0, 1'b0}  // R4 stopped
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_n(input logic rl, input logic rh, input int n);
    @(negedge clk);
    run_lo = rl; run_hi = rh;
    repeat (n) @(posedge clk);
    @(negedge clk);
    run_lo = 1'b0; run_hi = 1'b0;
  endtask

  task automatic wait_cap(output logic [15:0] v);
    v = '0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (cap_flag) begin
        v = reload_o;
        break;
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (cap_on) begin
      cap_ph++;
      if (cap_ph == 20) begin
        cap_in = ~cap_in;
        cap_ph = 0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [15:0] a, b, c1, c2, r0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 count", count_o, 16'h0);
    chk("R1 reload", reload_o, 16'h0);
    chk("R1 flags", {ovf_lo, ovf_hi, cap_flag}, 3'b000);

    for (int i = 0; i < NV; i++) begin
      wr(2'd2, 16'h0007);
      wr(2'd0, VECS[i].cnt);
      wr(2'd1, VECS[i].rld);
      split_en = VECS[i].split;
      run_n(VECS[i].rl, VECS[i].rh, int'(VECS[i].n));
      chk($sformatf("R3/R5/R6 vec%0d count", i), count_o, VECS[i].exp);
      chk($sformatf("R3/R5 vec%0d ovf_lo", i), ovf_lo, VECS[i].elo);
      chk($sformatf("R6 vec%0d ovf_hi", i), ovf_hi, VECS[i].ehi);
    end
    split_en = 1'b0;

    // R9 flags stay set until cleared; clearing one bit leaves the others
    wr(2'd0, 16'hFFFF);
    wr(2'd1, 16'h0000);
    split_en = 1'b1;
    run_n(1'b0, 1'b1, 1);
    split_en = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9 ovf_hi sticky", ovf_hi, 1'b1);
    wr(2'd2, 16'h0001);
    chk("R9 ovf_hi kept", ovf_hi, 1'b1);
    chk("R9 ovf_lo cleared", ovf_lo, 1'b0);
    wr(2'd2, 16'h0002);
    chk("R9 ovf_hi cleared", ovf_hi, 1'b0);

    // R2 count write wins over counting
    @(negedge clk);
    run_lo = 1'b1;
    wr(2'd0, 16'h7000);
    chk("R2 write overrides count", count_o, 16'h7000);
    run_lo = 1'b0;
    wr(2'd1, 16'hBEEF);
    chk("R2 reload write", reload_o, 16'hBEEF);

    // R7 divide by 12
    clk_sel = 2'd1;
    wr(2'd0, 16'h0000);
    run_n(1'b1, 1'b0, 24);
    chk("R7 sysclk/12", count_o, 16'd2);

    // R7 slow clock divided by 8
    clk_sel = 2'd2;
    wr(2'd0, 16'h0000);
    @(negedge clk);
    run_lo = 1'b1;
    for (int k = 0; k < 16; k++) begin
      repeat (3) @(negedge clk);
      slow_clk = 1'b1;
      repeat (3) @(negedge clk);
      slow_clk = 1'b0;
    end
    repeat (6) @(negedge clk);
    run_lo = 1'b0;
    chk("R7 slow/8", count_o, 16'd2);

    // R7 comparator edges
    clk_sel = 2'd3;
    wr(2'd0, 16'h0000);
    @(negedge clk);
    run_lo = 1'b1;
    for (int k = 0; k < 5; k++) begin
      repeat (2) @(negedge clk);
      cmp_in = 1'b1;
      repeat (2) @(negedge clk);
      cmp_in = 1'b0;
    end
    repeat (6) @(negedge clk);
    run_lo = 1'b0;
    chk("R7 comparator", count_o, 16'd5);

    // R8 capture: counter on sysclk even with the /12 select
    clk_sel = 2'd1;
    split_en = 1'b1;
    wr(2'd2, 16'h0007);
    @(negedge clk);
    capture_en = 1'b1;
    run_lo = 1'b1;
    @(negedge clk);
    c1 = count_o;
    @(negedge clk);
    c2 = count_o;
    chk("R8 counts every cycle", c2 - c1, 16'd1);
    cap_on = 1;
    wait_cap(a);
    chk("R8 first capture flag", cap_flag, 1'b1);
    wr(2'd2, 16'h0004);
    wait_cap(b);
    chk("R8 period 40", b - a, 16'd40);

    // R10 captures ignored when capture mode is off
    @(negedge clk);
    capture_en = 1'b0;
    split_en = 1'b0;
    wr(2'd2, 16'h0004);
    r0 = reload_o;
    repeat (100) @(negedge clk);
    chk("R10 reload unchanged", reload_o, r0);
    chk("R10 no capture flag", cap_flag, 1'b0);
    cap_on = 0;
    run_lo = 1'b0;

    // R1 reset again after activity
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 reset after use", {count_o, reload_o}, 32'h0);

    finish_run();
  end
endmodule